// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor, built as a microprogram. A control store on the chip holds one microinstruction per address. Each microinstruction has three fields: a bank of control bits, one bit per datapath control point; a 3-bit next-address selector; and an 8-bit branch target. On every clock the word at the next control address is loaded into a control buffer register. That register drives the control outputs directly. Its selector and target fields, together with the processor's condition inputs, choose the address that follows.

The microcode has four kinds of routine. The instruction fetch routine starts at address 0x00. The indirect-operand routine starts at 0x10, and the interrupt entry routine starts at 0x20. There is one execute routine per opcode, at 0x40 + 8 × opcode. The datapath receives the control outputs and returns the opcode, the indirect flag, the zero and carry flags, and a pending-interrupt request. The current control address is also brought out so that the sequencing can be observed.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `uaddr` = 0x00 and `ctrl_out` = 0. The first edge with `rst` low loads the word at 0x00 rather than skipping it.
- R2: Fetch runs three words: 0x00 (ctrl 0x001), 0x01 (ctrl 0x006), 0x02 (ctrl 0x008). Selector 0 (increment) moves to the current address plus one.
- R3: Selector 4 (opcode map), and selector 6 when the indirect flag is low, move to 0x40 + 8 × `opcode`. For opcode 7 this is 0x78.
- R4: Selector 6 with the indirect flag high moves to 0x10. The indirect routine runs 0x10 (ctrl 0x010), 0x11 (ctrl 0x002) and 0x12 (ctrl 0x020), then moves by opcode map.
- R5: Selector 2 branches to the target field when `flag_zero` is high and increments otherwise. Opcode 2 tests it at its first word, and its taken path reaches base+2 (ctrl 0x100).
- R6: Selector 3 does the same on `flag_carry`. Opcode 3 exercises it in the same layout.
- R7: Selector 1 always branches to the target field. Opcode 4 goes from its base straight to base+2 (ctrl 0x100).
- R8: Selector 5 with `irq` high moves to 0x20. The interrupt routine runs 0x20 (ctrl 0x040), 0x21 (ctrl 0x180) and 0x22 (ctrl 0x200), then jumps unconditionally to 0x00.
- R9: Selector 5 with `irq` low moves to 0x00.
- R10: Control bits are: 0 address←PC, 1 memory read into buffer, 2 PC increment, 3 IR load, 4 address←operand field, 5 operand field←buffer, 6 buffer←PC, 7 address←save slot, 8 PC load, 9 memory write, 10 ALU add, 11 accumulator load. Opcodes 0 and 1 run base (0x010), base+1 (0x002), then base+2 (0x800 or 0x400 respectively), and the flags have no effect on them. Opcodes 5 to 7 are one word with ctrl 0 and selector 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 3 | Opcode field of the instruction register |
| ind_bit | input | 1 | Indirect-addressing flag of the instruction |
| irq | input | 1 | Pending interrupt request |
| flag_zero | input | 1 | ALU zero flag |
| flag_carry | input | 1 | ALU carry flag |
| ctrl_out | output | 12 | Control bits from the control buffer register |
| uaddr | output | 8 | Current control address |

## Verification
Every result becomes visible one clock edge after the condition inputs are sampled. At each edge the next address and the new control word are registered together, so `uaddr` and `ctrl_out` always describe the same microinstruction. The bench changes its inputs and samples both outputs 2 ns after each rising edge. It moves exactly one edge between consecutive comparisons. Flags, opcode and interrupt are therefore set before the edge that consumes them and are checked at the next sample.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  parameter int AW        = 8;
  parameter int CTRL_W    = 12;
  parameter int OPC_W     = 3;
  parameter int MAP_SHIFT = 3;

  localparam int NUM_OPC     = 1 << OPC_W;
  localparam int ROUTINE_LEN = 1 << MAP_SHIFT;

  localparam logic [AW-1:0] FETCH_ADDR = AW'('h00);
  localparam logic [AW-1:0] IND_ADDR   = AW'('h10);
  localparam logic [AW-1:0] INT_ADDR   = AW'('h20);
  localparam logic [AW-1:0] MAP_BASE   = AW'('h40);

  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_JMP  = 3'd1,
    SEL_BZ   = 3'd2,
    SEL_BC   = 3'd3,
    SEL_MAP  = 3'd4,
    SEL_FI   = 3'd5,
    SEL_IE   = 3'd6,
    SEL_RSV  = 3'd7
  } nsel_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    nsel_e             sel;
    logic [AW-1:0]     target;
  } uword_t;

  // control-point bit indices
  localparam int B_MAR_PC   = 0;
  localparam int B_MBR_MEM  = 1;
  localparam int B_PC_INC   = 2;
  localparam int B_IR_MBR   = 3;
  localparam int B_MAR_IRA  = 4;
  localparam int B_IRA_MBR  = 5;
  localparam int B_MBR_PC   = 6;
  localparam int B_MAR_SAVE = 7;
  localparam int B_PC_LOAD  = 8;
  localparam int B_MEM_WR   = 9;
  localparam int B_ALU_ADD  = 10;
  localparam int B_AC_MBR   = 11;

  // opcode numbering
  localparam int OP_LOAD = 0;
  localparam int OP_ADD  = 1;
  localparam int OP_JZ   = 2;
  localparam int OP_JC   = 3;
  localparam int OP_JMP  = 4;

  function automatic logic [CTRL_W-1:0] cbit(input int idx);
    return CTRL_W'(1) << idx;
  endfunction

  function automatic uword_t mk(input logic [CTRL_W-1:0] c, input nsel_e s,
                                input logic [AW-1:0] t);
    uword_t w;
    w.ctrl   = c;
    w.sel    = s;
    w.target = t;
    return w;
  endfunction
endpackage

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output uword_t        cbr
);

  // execute-routine words, k = word offset inside the routine
  function automatic uword_t op_word(input int op, input int k,
                                     input logic [AW-1:0] skip_tgt);
    uword_t w;
    w = mk('0, SEL_INC, '0);
    case (op)
      OP_LOAD, OP_ADD: begin
        case (k)
          0: w = mk(cbit(B_MAR_IRA), SEL_INC, '0);
          1: w = mk(cbit(B_MBR_MEM), SEL_INC, '0);
          2: begin
            if (op == OP_LOAD) w = mk(cbit(B_AC_MBR), SEL_FI, '0);
            else               w = mk(cbit(B_ALU_ADD), SEL_FI, '0);
          end
          default: w = mk('0, SEL_INC, '0);
        endcase
      end
      OP_JZ, OP_JC: begin
        case (k)
          0: begin
            if (op == OP_JZ) w = mk('0, SEL_BZ, skip_tgt);
            else             w = mk('0, SEL_BC, skip_tgt);
          end
          1: w = mk('0, SEL_FI, '0);
          2: w = mk(cbit(B_PC_LOAD), SEL_FI, '0);
          default: w = mk('0, SEL_INC, '0);
        endcase
      end
      OP_JMP: begin
        case (k)
          0: w = mk('0, SEL_JMP, skip_tgt);
          2: w = mk(cbit(B_PC_LOAD), SEL_FI, '0);
          default: w = mk('0, SEL_INC, '0);
        endcase
      end
      default: begin
        if (k == 0) w = mk('0, SEL_FI, '0);
      end
    endcase
    return w;
  endfunction

  function automatic uword_t rom_word(input logic [AW-1:0] a);
    uword_t w;
    int off;
    int op;
    int k;
    w   = mk('0, SEL_INC, '0);
    off = int'(a) - int'(MAP_BASE);
    case (a)
      FETCH_ADDR:             w = mk(cbit(B_MAR_PC), SEL_INC, '0);
      FETCH_ADDR + AW'(1):    w = mk(cbit(B_MBR_MEM) | cbit(B_PC_INC), SEL_INC, '0);
      FETCH_ADDR + AW'(2):    w = mk(cbit(B_IR_MBR), SEL_IE, '0);
      IND_ADDR:               w = mk(cbit(B_MAR_IRA), SEL_INC, '0);
      IND_ADDR + AW'(1):      w = mk(cbit(B_MBR_MEM), SEL_INC, '0);
      IND_ADDR + AW'(2):      w = mk(cbit(B_IRA_MBR), SEL_MAP, '0);
      INT_ADDR:               w = mk(cbit(B_MBR_PC), SEL_INC, '0);
      INT_ADDR + AW'(1):      w = mk(cbit(B_MAR_SAVE) | cbit(B_PC_LOAD), SEL_INC, '0);
      INT_ADDR + AW'(2):      w = mk(cbit(B_MEM_WR), SEL_JMP, FETCH_ADDR);
      default: begin
        if (off >= 0 && off < NUM_OPC * ROUTINE_LEN) begin
          op = off / ROUTINE_LEN;
          k  = off % ROUTINE_LEN;
          w  = op_word(op, k, AW'(int'(a) - k + 2));
        end
      end
    endcase
    return w;
  endfunction

  // synchronous read into the control buffer register
  always_ff @(posedge clk) begin
    if (rst) cbr <= '0;
    else     cbr <= rom_word(rd_addr);
  end

endmodule

// File: rtl/ucs_next.sv
module ucs_next
  import ucs_pkg::*;
(
  input  logic             primed,
  input  logic [AW-1:0]    car,
  input  nsel_e            sel,
  input  logic [AW-1:0]    target,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ind_bit,
  input  logic             irq,
  input  logic             flag_zero,
  input  logic             flag_carry,
  output logic [AW-1:0]    nxt
);

  logic [AW-1:0] seq_addr;
  logic [AW-1:0] map_addr;

  assign seq_addr = car + AW'(1);
  assign map_addr = MAP_BASE + (AW'(opcode) << MAP_SHIFT);

  always_comb begin
    nxt = seq_addr;
    if (!primed) begin
      nxt = car;
    end else begin
      case (sel)
        SEL_INC: nxt = seq_addr;
        SEL_JMP: nxt = target;
        SEL_BZ:  nxt = flag_zero  ? target : seq_addr;
        SEL_BC:  nxt = flag_carry ? target : seq_addr;
        SEL_MAP: nxt = map_addr;
        SEL_FI:  nxt = irq ? INT_ADDR : FETCH_ADDR;
        SEL_IE:  nxt = ind_bit ? IND_ADDR : map_addr;
        default: nxt = seq_addr;
      endcase
    end
  end

endmodule

// File: rtl/ucs_addr_reg.sv
module ucs_addr_reg
  import ucs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] car,
  output logic          primed
);

  always_ff @(posedge clk) begin
    if (rst) begin
      car    <= FETCH_ADDR;
      primed <= 1'b0;
    end else begin
      car    <= nxt;
      primed <= 1'b1;
    end
  end

  // a reset cycle always leaves the address at the fetch entry
  assert_reset_fetch_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> car == FETCH_ADDR);

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ind_bit,
  input  logic             irq,
  input  logic             flag_zero,
  input  logic             flag_carry,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [AW-1:0]    uaddr
);

  uword_t        cbr;
  logic [AW-1:0] car;
  logic [AW-1:0] nxt;
  logic          primed;

  ucs_addr_reg u_car (
    .clk    (clk),
    .rst    (rst),
    .nxt    (nxt),
    .car    (car),
    .primed (primed)
  );

  ucs_next u_next (
    .primed     (primed),
    .car        (car),
    .sel        (cbr.sel),
    .target     (cbr.target),
    .opcode     (opcode),
    .ind_bit    (ind_bit),
    .irq        (irq),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .nxt        (nxt)
  );

  ucs_store u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (nxt),
    .cbr     (cbr)
  );

  assign ctrl_out = cbr.ctrl;
  assign uaddr    = car;

  assert_dark_until_primed_R1: assert property (@(posedge clk) disable iff (rst)
    !primed |-> ctrl_out == '0);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_INC |=> uaddr == $past(uaddr) + AW'(1));

  assert_map_entry_R3: assert property (@(posedge clk) disable iff (rst)
    primed && (cbr.sel == SEL_MAP || (cbr.sel == SEL_IE && !ind_bit))
    |=> uaddr[MAP_SHIFT-1:0] == '0 && uaddr >= MAP_BASE);

  assert_indirect_entry_R4: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_IE && ind_bit |=> uaddr == IND_ADDR);

  assert_zero_taken_R5: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_BZ && flag_zero |=> uaddr == $past(cbr.target));

  assert_zero_fallthru_R5: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_BZ && !flag_zero |=> uaddr == $past(uaddr) + AW'(1));

  assert_carry_taken_R6: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_BC && flag_carry |=> uaddr == $past(cbr.target));

  assert_carry_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_BC && !flag_carry |=> uaddr == $past(uaddr) + AW'(1));

  assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_JMP |=> uaddr == $past(cbr.target));

  assert_irq_entry_R8: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_FI && irq |=> uaddr == INT_ADDR);

  assert_fetch_return_R9: assert property (@(posedge clk) disable iff (rst)
    primed && cbr.sel == SEL_FI && !irq |=> uaddr == FETCH_ADDR);

endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opcode = '0;
  logic        ind_bit = 1'b0;
  logic        irq = 1'b0;
  logic        flag_zero = 1'b0;
  logic        flag_carry = 1'b0;
  logic [11:0] ctrl_out;
  logic [7:0]  uaddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ucode_sequencer dut (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .ind_bit    (ind_bit),
    .irq        (irq),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .ctrl_out   (ctrl_out),
    .uaddr      (uaddr)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] ea, input logic [11:0] ec);
    n_cmp++;
    if (uaddr !== ea || ctrl_out !== ec) begin
      n_bad++;
      $display("FAIL %s: uaddr=%h ctrl=%h expected uaddr=%h ctrl=%h",
               req, uaddr, ctrl_out, ea, ec);
    end
  endtask

  // one full instruction from fetch back to fetch (through interrupt if rq)
  task automatic run_instr(input int op, input bit ind, input bit z,
                           input bit c, input bit rq);
    logic [7:0] b;
    b = 8'(8'h40 + op * 8);
    chk("R2", 8'h00, 12'h001); tick;
    chk("R2", 8'h01, 12'h006); tick;
    chk("R2", 8'h02, 12'h008);
    opcode = 3'(op); ind_bit = ind; flag_zero = z; flag_carry = c; irq = rq;
    tick;
    if (ind) begin
      chk("R4", 8'h10, 12'h010); tick;
      chk("R4", 8'h11, 12'h002); tick;
      chk("R4", 8'h12, 12'h020); tick;
    end
    case (op)
      0, 1: begin
        chk("R3", b, 12'h010); tick;
        chk("R10", b + 8'd1, 12'h002); tick;
        chk("R10", b + 8'd2, (op == 0) ? 12'h800 : 12'h400);
      end
      2, 3: begin
        chk("R3", b, 12'h000); tick;
        if ((op == 2) ? z : c) chk((op == 2) ? "R5" : "R6", b + 8'd2, 12'h100);
        else                   chk((op == 2) ? "R5" : "R6", b + 8'd1, 12'h000);
      end
      4: begin
        chk("R3", b, 12'h000); tick;
        chk("R7", b + 8'd2, 12'h100);
      end
      default: chk("R10", b, 12'h000);
    endcase
    tick;
    if (rq) begin
      chk("R8", 8'h20, 12'h040); tick;
      chk("R8", 8'h21, 12'h180); tick;
      chk("R8", 8'h22, 12'h200); tick;
      irq = 1'b0;
      chk("R8", 8'h00, 12'h001);
    end else begin
      chk("R9", 8'h00, 12'h001);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick; tick;
    chk("R1", 8'h00, 12'h000);
    rst = 1'b0;
    tick;
    chk("R1", 8'h00, 12'h001);
  endtask

  task automatic t_load_plain();   run_instr(0, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_add_indirect(); run_instr(1, 1'b1, 1'b1, 1'b1, 1'b0); endtask
  task automatic t_zero_branch();
    run_instr(2, 1'b0, 1'b1, 1'b0, 1'b0);
    run_instr(2, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic t_carry_branch();
    run_instr(3, 1'b0, 1'b0, 1'b1, 1'b0);
    run_instr(3, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask
  task automatic t_jump();         run_instr(4, 1'b0, 1'b0, 1'b0, 1'b0); endtask
  task automatic t_irq_paths();
    run_instr(7, 1'b0, 1'b0, 1'b0, 1'b1);
    run_instr(1, 1'b1, 1'b0, 1'b0, 1'b1);
    run_instr(5, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mid_reset();
    run_instr(6, 1'b0, 1'b0, 1'b0, 1'b0);
    tick;
    rst = 1'b1;
    tick;
    chk("R1", 8'h00, 12'h000);
    tick;
    chk("R1", 8'h00, 12'h000);
    rst = 1'b0;
    tick;
    run_instr(0, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_load_plain();
    t_add_indirect();
    t_zero_branch();
    t_carry_branch();
    t_jump();
    t_irq_paths();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R1..): run still active, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule